// File: doc/BRIEF.md
# Four-Stage Mode-Select Shift Register

This block is a four-stage clocked register. A two-bit mode input picks how data enters and leaves it: serial or parallel on the way in, and serial or parallel on the way out. The mode does not choose between hold, left shift, right shift and load. In every shifting mode the data moves one stage per clock, from the most significant stage toward the least significant stage. The incoming serial bit enters at the top, and the serial output is the bottom stage.

Both outputs are always live. The parallel output shows the whole register and the serial output shows its lowest stage. Each mode therefore only decides what the next register value is. Mode codes are 00 serial-to-parallel, 01 serial-to-serial, 10 parallel-to-serial and 11 parallel-to-parallel. In mode 10 a load strobe takes in the parallel word. Without the strobe that mode shifts down and fills the top stage with zero. A synchronous reset clears the register and overrides every mode.

Top module: `quad_stage_shifter`

## Requirements
- R1: When `srst` is high at a rising edge, all four stages become 0 on that edge, whatever the mode, strobe or data inputs.
- R2: In mode 00, each edge moves the register one stage down: the new value is {ser_in, old[3:1]}, so the newest bit sits in bit 3 of `par_out`.
- R3: In mode 01, the same one-stage move happens. A bit presented on `ser_in` reaches `ser_out` after exactly four edges.
- R4: In mode 10 with `load_stb` high, the edge stores `par_in` unchanged into the register.
- R5: In mode 10 with `load_stb` low, the edge produces {0, old[3:1]}: the register shifts down and the top stage fills with zero.
- R6: In mode 11, each edge stores `par_in` in the register. `load_stb` has no effect in this mode.
- R7: In modes 00 and 01, `load_stb` has no effect. The shift still takes in `ser_in`.
- R8: In modes 10 and 11, `ser_in` has no effect on the stored value.
- R9: `par_out` always equals the register contents. `ser_out` always equals `par_out[0]`, so before an edge it shows the bit that edge shifts out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high, highest priority |
| ser_in | input | 1 | Serial data entering the top stage |
| par_in | input | 4 | Parallel data word |
| load_stb | input | 1 | Capture strobe used in mode 10 |
| mode_sel | input | 2 | 00 ser-par, 01 ser-ser, 10 par-ser, 11 par-par |
| par_out | output | 4 | Current register contents |
| ser_out | output | 1 | Current lowest stage |

## Verification
The assertions assume that `srst` is held high at least through the first rising edge, so that no property looks back at register values left over from power-up. They also assume that `mode_sel`, `load_stb`, `ser_in` and `par_in` are settled before each rising edge, because each property compares the value after an edge with the inputs sampled at that edge. The bench raises reset at time zero and changes every input only on falling edges, half a period away from the sampling edge. It tries all four mode codes with the strobe both high and low, and it ends with reset applied on top of an active load.

// File: rtl/qss_pkg.sv
package qss_pkg;

    typedef enum logic [1:0] {
        MODE_SER_PAR = 2'b00,
        MODE_SER_SER = 2'b01,
        MODE_PAR_SER = 2'b10,
        MODE_PAR_PAR = 2'b11
    } mode_e;

endpackage

// File: rtl/shift_next_sel.sv
module shift_next_sel
    import qss_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e              mode,
    input  logic               load,
    input  logic               ser_bit,
    input  logic [WIDTH-1:0]   par_word,
    input  logic [WIDTH-1:0]   cur,
    output logic [WIDTH-1:0]   nxt
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] down_ser;
    logic [WIDTH-1:0] down_zero;

    // One-stage move toward the least significant end.
    assign down_ser  = {ser_bit, cur[TOP:1]};
    assign down_zero = {1'b0,    cur[TOP:1]};

    always_comb begin
        nxt = cur;
        unique case (mode)
            MODE_SER_PAR,
            MODE_SER_SER: nxt = down_ser;
            MODE_PAR_SER: nxt = load ? par_word : down_zero;
            MODE_PAR_PAR: nxt = par_word;
        endcase
    end

endmodule

// File: rtl/stage_bank.sv
module stage_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             srst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic r;
        always_ff @(posedge clk) begin
            if (srst) r <= 1'b0;
            else      r <= d[i];
        end
        assign q[i] = r;
    end

endmodule

// File: rtl/quad_stage_shifter.sv
module quad_stage_shifter
    import qss_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    input  logic             load_stb,
    input  logic [1:0]       mode_sel,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out
);

    mode_e            mode;
    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] stages_nxt;

    assign mode = mode_e'(mode_sel);

    shift_next_sel #(.WIDTH(WIDTH)) u_next (
        .mode     (mode),
        .load     (load_stb),
        .ser_bit  (ser_in),
        .par_word (par_in),
        .cur      (stages),
        .nxt      (stages_nxt)
    );

    stage_bank #(.WIDTH(WIDTH)) u_bank (
        .clk  (clk),
        .srst (srst),
        .d    (stages_nxt),
        .q    (stages)
    );

    // Outputs: contents and lowest stage, valid in every mode.
    always_comb begin
        par_out = stages;
        ser_out = stages[0];
    end

endmodule

// File: rtl/quad_stage_shifter_chk.sv
module quad_stage_shifter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             srst,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic             load_stb,
    input logic [1:0]       mode_sel,
    input logic [WIDTH-1:0] par_out,
    input logic             ser_out
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        srst |=> (par_out == '0));

    // R2 and R3 (modes 00/01), R7 (strobe ignored there)
    assert_serial_shift_R2: assert property (@(posedge clk) disable iff (srst)
        (mode_sel[1] == 1'b0) |=>
            (par_out == {$past(ser_in), $past(par_out[WIDTH-1:1])}));

    assert_par_capture_R4: assert property (@(posedge clk) disable iff (srst)
        (mode_sel == 2'b10 && load_stb) |=> (par_out == $past(par_in)));

    // R5 and R8 (ser_in ignored while draining)
    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (srst)
        (mode_sel == 2'b10 && !load_stb) |=>
            (par_out == {1'b0, $past(par_out[WIDTH-1:1])}));

    assert_par_store_R6: assert property (@(posedge clk) disable iff (srst)
        (mode_sel == 2'b11) |=> (par_out == $past(par_in)));

    assert_ser_tap_R9: assert property (@(posedge clk) disable iff (srst)
        ser_out == par_out[0]);

endmodule

bind quad_stage_shifter quad_stage_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .srst     (srst),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .load_stb (load_stb),
    .mode_sel (mode_sel),
    .par_out  (par_out),
    .ser_out  (ser_out)
);

// File: tb/tb_quad_stage_shifter.sv
module tb_quad_stage_shifter;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       ser_in = 1'b0;
    logic [3:0] par_in = 4'b0;
    logic       load_stb = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [3:0] par_out;
    logic       ser_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    quad_stage_shifter dut (
        .clk      (clk),
        .srst     (srst),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .load_stb (load_stb),
        .mode_sel (mode_sel),
        .par_out  (par_out),
        .ser_out  (ser_out)
    );

    // Fields: [12] srst, [11:10] mode, [9] load, [8] ser, [7:4] par, [3:0] expected par_out
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 2'b11, 1'b1, 1'b1, 4'b1111, 4'b0000}, // R1 reset beats mode 11
        {1'b0, 2'b00, 1'b0, 1'b1, 4'b0000, 4'b1000}, // R2
        {1'b0, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0100}, // R2
        {1'b0, 2'b00, 1'b1, 1'b1, 4'b1111, 4'b1010}, // R7
        {1'b0, 2'b00, 1'b0, 1'b1, 4'b0000, 4'b1101}, // R2
        {1'b0, 2'b01, 1'b0, 1'b0, 4'b0000, 4'b0110}, // R3
        {1'b0, 2'b01, 1'b0, 1'b0, 4'b0000, 4'b0011}, // R3
        {1'b0, 2'b01, 1'b1, 1'b1, 4'b1111, 4'b1001}, // R7
        {1'b0, 2'b01, 1'b0, 1'b0, 4'b0000, 4'b0100}, // R3
        {1'b0, 2'b11, 1'b0, 1'b1, 4'b1010, 4'b1010}, // R6, R8
        {1'b0, 2'b11, 1'b1, 1'b0, 4'b0101, 4'b0101}, // R6
        {1'b0, 2'b10, 1'b1, 1'b0, 4'b1011, 4'b1011}, // R4
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b1111, 4'b0101}, // R5, R8
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b0000, 4'b0010}, // R5
        {1'b0, 2'b10, 1'b0, 1'b0, 4'b0000, 4'b0001}, // R5
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b0000, 4'b0000}, // R5
        {1'b0, 2'b10, 1'b1, 1'b1, 4'b1110, 4'b1110}, // R4
        {1'b1, 2'b10, 1'b1, 1'b1, 4'b1111, 4'b0000}  // R1 reset beats load
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive_edge(input logic r, input logic [1:0] m, input logic ld,
                              input logic s, input logic [3:0] p);
        @(negedge clk);
        srst = r; mode_sel = m; load_stb = ld; ser_in = s; par_in = p;
        @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #5;
        check("R1", par_out, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            drive_edge(VEC[i][12], VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
            check($sformatf("R2-R8 vector %0d", i), par_out, VEC[i][3:0]);
            check("R9 ser_out tap", {3'b0, ser_out}, {3'b0, VEC[i][0]});
        end

        // R3: a single 1 reaches ser_out after exactly four edges
        drive_edge(1'b0, 2'b01, 1'b0, 1'b1, 4'b0000);
        check("R3 latency edge1", {3'b0, ser_out}, 4'b0000);
        drive_edge(1'b0, 2'b01, 1'b0, 1'b0, 4'b0000);
        check("R3 latency edge2", {3'b0, ser_out}, 4'b0000);
        drive_edge(1'b0, 2'b01, 1'b0, 1'b0, 4'b0000);
        check("R3 latency edge3", {3'b0, ser_out}, 4'b0000);
        drive_edge(1'b0, 2'b01, 1'b0, 1'b0, 4'b0000);
        check("R3 latency edge4", {3'b0, ser_out}, 4'b0001);
        check("R3 contents", par_out, 4'b0001);

        // R5: strobe low in mode 10 drains to zero even with ser_in high
        drive_edge(1'b0, 2'b10, 1'b0, 1'b1, 4'b1111);
        check("R5 drain", par_out, 4'b0000);

        // R1: reset during serial mode
        drive_edge(1'b0, 2'b11, 1'b0, 1'b0, 4'b1111);
        drive_edge(1'b1, 2'b00, 1'b0, 1'b1, 4'b1111);
        check("R1 reset in mode 00", par_out, 4'b0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule